// File: doc/BRIEF.md
# Stored-Replica Spreading Sequence Transmitter

This block spreads a serial bit stream by playing back stored, pre-shaped spreading sequence samples. There are two sample memories, one for the in-phase branch and one for the quadrature branch. Each memory holds two replicas of a sequence: one stands for a data 0 and one for a data 1. While transmission is enabled, a sample counter steps through the sequence once per sample clock. The branch data bit latched at the start of each symbol is used as the top address bit, so it picks which replica is read out. The two registered memory outputs are signed baseband samples. They feed the digital-to-analog stage further down the chain.

A serial-to-parallel stage collects the incoming bits. In dual channel mode, each symbol takes two new bits: the in-phase branch gets the older one and the quadrature branch gets the newer one. In balanced mode, each symbol takes one bit and both branches get that same bit. The symbol period is the samples-per-chip count times the programmed sequence length, in sample clocks. A bit-request output pulses once per symbol in balanced mode and twice per symbol in dual channel mode. It tells the bit source when to present the next bit. A host loads the memories through a write port while transmission is off.

Top module: `seq_playback_tx`

## Requirements
- R1: After synchronous reset, out_i and out_q are zero and bit_tick is low.
- R2: While tx_en is low, out_i and out_q are zero from the next clock on and bit_tick is low. Each time tx_en rises, playback restarts at sample index 0 of a new symbol.
- R3: A host write stores wr_data into the I memory (wr_branch = 0) or the Q memory (wr_branch = 1). The write address is {replica bit, sample index}: the top bit selects the data-1 replica when 1. A write is stored only while tx_en is low. A write attempted while tx_en is high leaves the memory unchanged.
- R4: Let S = SPC × seq_len, and count enabled clock edges from 1 starting at the rising of tx_en. In the cycle after enabled edge k, each output equals that branch's memory word at {symbol bit, (k−1) mod S}.
- R5: In dual channel mode (mode = 0), at each symbol start the I bit is the older and the Q bit is the newer of the two most recently strobed input bits.
- R6: In balanced mode (mode = 1), at each symbol start both branch bits equal the most recently strobed input bit.
- R7: Branch bits are captured only at a symbol start. Bits strobed during a symbol do not change the samples of that symbol.
- R8: While enabled, bit_tick is high in the cycle after enabled edge k whenever k mod S = S−1. In dual channel mode it is also high whenever k mod S = S/2−1.
- R9: The symbol length follows seq_len for any value from 1 to MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; host writes are blocked while high |
| mode | input | 1 | 0 = dual channel, 1 = balanced |
| seq_len | input | LEN_W | Sequence length in chips, 1..MAX_LEN |
| bit_in | input | 1 | Serial data bit |
| bit_stb | input | 1 | Shifts bit_in into the serial-to-parallel stage |
| bit_tick | output | 1 | Request for the next serial bit |
| wr_en | input | 1 | Host write strobe |
| wr_branch | input | 1 | 0 = I memory, 1 = Q memory |
| wr_addr | input | AW | {replica bit, sample index} |
| wr_data | input | SAMPLE_W | Signed sample to store |
| out_i | output | SAMPLE_W | Signed in-phase sample |
| out_q | output | SAMPLE_W | Signed quadrature sample |

## Verification
The checker keeps its own count of enabled cycles to predict bit_tick. For that count to be valid, mode and seq_len must change only while tx_en is low, and seq_len must stay between 1 and MAX_LEN. The stimulus sets both parameters during idle gaps between runs and never touches them during playback. It presents bits only at sample positions 1 and 2 of a symbol, never on the edge that opens a symbol, so the bit captured at each symbol start is unambiguous.

// File: rtl/seqtx_pkg.sv
package seqtx_pkg;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_BAL  = 1'b1
    } tx_mode_e;

    typedef struct packed {
        logic i;
        logic q;
    } br_bits_t;

    // sp[1] is the older bit, sp[0] the most recent one
    function automatic br_bits_t map_bits(tx_mode_e m, logic [1:0] sp);
        br_bits_t r;
        if (m == MODE_DUAL) begin
            r.i = sp[1];
            r.q = sp[0];
        end else begin
            r.i = sp[0];
            r.q = sp[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/seqtx_timing.sv
module seqtx_timing
    import seqtx_pkg::*;
#(
    parameter int SPC    = 4,
    parameter int LEN_W  = 9,
    parameter int SIDX_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  tx_mode_e          mode,
    input  logic [LEN_W-1:0]  seq_len,
    output logic [SIDX_W-1:0] cnt,
    output logic              sym_start,
    output logic              bit_tick
);
    localparam int CW = SIDX_W + 1;

    logic [CW-1:0] total;
    logic [CW-1:0] last;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt_ext;

    assign total   = CW'(seq_len) * CW'(SPC);
    assign last    = total - CW'(1);
    assign half    = (total >> 1) - CW'(1);
    assign cnt_ext = {1'b0, cnt};

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            cnt <= '0;
        end else if (cnt_ext == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + SIDX_W'(1);
        end
    end

    assign sym_start = tx_en && (cnt == '0);
    assign bit_tick  = tx_en && ((cnt_ext == last) ||
                                 ((mode == MODE_DUAL) && (cnt_ext == half)));
endmodule

// File: rtl/seqtx_sp.sv
module seqtx_sp
    import seqtx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_in,
    input  logic     bit_stb,
    input  tx_mode_e mode,
    input  logic     sym_start,
    output br_bits_t sel
);
    logic [1:0] sp_q;
    br_bits_t   lat_q;
    br_bits_t   fresh;

    assign fresh = map_bits(mode, sp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            lat_q <= '0;
        end else begin
            if (bit_stb) begin
                sp_q <= {sp_q[0], bit_in};
            end
            if (sym_start) begin
                lat_q <= fresh;
            end
        end
    end

    // the opening sample of a symbol already uses the new bits
    assign sel = sym_start ? fresh : lat_q;
endmodule

// File: rtl/seqtx_mem.sv
module seqtx_mem #(
    parameter int SAMPLE_W = 8,
    parameter int AW       = 11
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic signed [SAMPLE_W-1:0] wr_data,
    input  logic                       rd_en,
    input  logic [AW-1:0]              rd_addr,
    output logic signed [SAMPLE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic signed [SAMPLE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rd_en) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/seq_playback_tx.sv
module seq_playback_tx
    import seqtx_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int SPC      = 4,
    parameter int MAX_LEN  = 256,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int SIDX_W  = $clog2(SPC * MAX_LEN),
    localparam int AW      = SIDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tx_en,
    input  logic                       mode,
    input  logic [LEN_W-1:0]           seq_len,
    input  logic                       bit_in,
    input  logic                       bit_stb,
    output logic                       bit_tick,
    input  logic                       wr_en,
    input  logic                       wr_branch,
    input  logic [AW-1:0]              wr_addr,
    input  logic signed [SAMPLE_W-1:0] wr_data,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q
);
    tx_mode_e                   mode_e;
    logic [SIDX_W-1:0]          cnt;
    logic                       sym_start;
    br_bits_t                   sel;
    logic signed [SAMPLE_W-1:0] rdata [2];

    assign mode_e = tx_mode_e'(mode);

    seqtx_timing #(
        .SPC   (SPC),
        .LEN_W (LEN_W),
        .SIDX_W(SIDX_W)
    ) u_tim (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .mode     (mode_e),
        .seq_len  (seq_len),
        .cnt      (cnt),
        .sym_start(sym_start),
        .bit_tick (bit_tick)
    );

    seqtx_sp u_sp (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_stb  (bit_stb),
        .mode     (mode_e),
        .sym_start(sym_start),
        .sel      (sel)
    );

    for (genvar b = 0; b < 2; b++) begin : g_br
        logic          br_bit;
        logic          br_wr;
        logic [AW-1:0] br_raddr;

        assign br_bit   = (b == 0) ? sel.i : sel.q;
        assign br_wr    = wr_en && !tx_en && (wr_branch == 1'(b));
        assign br_raddr = {br_bit, cnt};

        seqtx_mem #(
            .SAMPLE_W(SAMPLE_W),
            .AW      (AW)
        ) u_mem (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (br_wr),
            .wr_addr(wr_addr),
            .wr_data(wr_data),
            .rd_en  (tx_en),
            .rd_addr(br_raddr),
            .rd_data(rdata[b])
        );
    end

    assign out_i = rdata[0];
    assign out_q = rdata[1];
endmodule

// File: rtl/seqtx_chk.sv
module seqtx_chk #(
    parameter int SAMPLE_W = 8,
    parameter int SPC      = 4,
    parameter int MAX_LEN  = 256,
    parameter int LEN_W    = 9,
    parameter int SIDX_W   = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tx_en,
    input logic                       mode,
    input logic [LEN_W-1:0]           seq_len,
    input logic                       bit_tick,
    input logic signed [SAMPLE_W-1:0] out_i,
    input logic signed [SAMPLE_W-1:0] out_q
);
    localparam int CW = SIDX_W + 1;

    logic [CW-1:0] run_cnt;
    logic [CW-1:0] per;
    logic [CW-1:0] per_last;
    logic [CW-1:0] per_half;

    assign per      = CW'(seq_len) * CW'(SPC);
    assign per_last = per - CW'(1);
    assign per_half = (per >> 1) - CW'(1);

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            run_cnt <= '0;
        end else if (run_cnt == per_last) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (out_i == '0 && out_q == '0)); // R2

    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !bit_tick); // R2

    AST_TICK_BAL: assert property (@(posedge clk) disable iff (rst)
        (tx_en && mode) |-> (bit_tick == (run_cnt == per_last))); // R8

    AST_TICK_DUAL: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !mode) |->
            (bit_tick == ((run_cnt == per_last) || (run_cnt == per_half)))); // R8
endmodule

bind seq_playback_tx seqtx_chk #(
    .SAMPLE_W(SAMPLE_W),
    .SPC     (SPC),
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .SIDX_W  (SIDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .mode    (mode),
    .seq_len (seq_len),
    .bit_tick(bit_tick),
    .out_i   (out_i),
    .out_q   (out_q)
);

// File: tb/sim_seq_playback_tx.sv
module sim_seq_playback_tx;
    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_W   = 8;
    localparam int SPC        = 4;
    localparam int MAX_LEN    = 8;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);
    localparam int SIDX_W     = $clog2(SPC * MAX_LEN);
    localparam int AW         = SIDX_W + 1;
    localparam int DEPTH      = 1 << AW;
    localparam int HALF_DEPTH = DEPTH / 2;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       tx_en = 1'b0;
    logic                       mode = 1'b0;
    logic [LEN_W-1:0]           seq_len = LEN_W'(1);
    logic                       bit_in = 1'b0;
    logic                       bit_stb = 1'b0;
    logic                       bit_tick;
    logic                       wr_en = 1'b0;
    logic                       wr_branch = 1'b0;
    logic [AW-1:0]              wr_addr = '0;
    logic signed [SAMPLE_W-1:0] wr_data = '0;
    logic signed [SAMPLE_W-1:0] out_i;
    logic signed [SAMPLE_W-1:0] out_q;

    seq_playback_tx #(
        .SAMPLE_W(SAMPLE_W),
        .SPC     (SPC),
        .MAX_LEN (MAX_LEN)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .mode     (mode),
        .seq_len  (seq_len),
        .bit_in   (bit_in),
        .bit_stb  (bit_stb),
        .bit_tick (bit_tick),
        .wr_en    (wr_en),
        .wr_branch(wr_branch),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .out_i    (out_i),
        .out_q    (out_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int                         n_cmp = 0;
    int                         n_bad = 0;
    bit                         done = 1'b0;
    logic signed [SAMPLE_W-1:0] mem_m [2][DEPTH];
    logic [1:0]                 sp_m = 2'b00;
    logic [15:0]                lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic strobe_bit();
        logic b;
        b       = next_bit();
        bit_in  = b;
        bit_stb = 1'b1;
        sp_m    = {sp_m[0], b};
    endtask

    task automatic host_write(input int br, input int addr, input int val);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_branch = br[0];
        wr_addr   = AW'(addr);
        wr_data   = SAMPLE_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_idle(input string req, input int ncyc);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            chk(out_i == '0, req, "out_i idle", int'(out_i), 0);
            chk(out_q == '0, req, "out_q idle", int'(out_q), 0);
            chk(bit_tick == 1'b0, req, "bit_tick idle", int'(bit_tick), 0);
        end
    endtask

    // md: 0 dual, 1 balanced
    task automatic run(input logic md, input int len, input int nsym,
                       input bit blocked_wr);
        int   s;
        int   idx;
        int   ei;
        int   eq;
        logic cur_i;
        logic cur_q;
        bit   etick;
        string rq;
        s     = SPC * len;
        cur_i = 1'b0;
        cur_q = 1'b0;
        rq    = md ? "R4 R6 R9" : "R4 R5 R9";
        @(negedge clk);
        mode    = md;
        seq_len = LEN_W'(len);
        strobe_bit();
        @(negedge clk);
        strobe_bit();
        @(negedge clk);
        bit_stb = 1'b0;
        tx_en   = 1'b1;
        for (int k = 1; k <= nsym * s; k++) begin
            @(negedge clk);
            idx = (k - 1) % s;
            if (idx == 0) begin
                cur_i = md ? sp_m[0] : sp_m[1];
                cur_q = sp_m[0];
            end
            ei = int'(mem_m[0][int'(cur_i) * HALF_DEPTH + idx]);
            eq = int'(mem_m[1][int'(cur_q) * HALF_DEPTH + idx]);
            // R7: strobes earlier in this symbol must not change these samples
            chk(int'(out_i) == ei, rq, "out_i sample", int'(out_i), ei);
            chk(int'(out_q) == eq, rq, "out_q sample", int'(out_q), eq);
            etick = (k % s == s - 1) || (!md && (k % s == s / 2 - 1));
            chk(bit_tick == etick, "R8", "bit_tick", int'(bit_tick), int'(etick));
            bit_stb = 1'b0;
            wr_en   = 1'b0;
            if (k % s == 1) strobe_bit();
            if (!md && (k % s == 2)) strobe_bit();
            if (blocked_wr && (k == s + 2 || k == s + 3)) begin
                // R3: ignored while enabled, model untouched
                wr_en     = 1'b1;
                wr_branch = 1'b0;
                wr_addr   = (k == s + 2) ? AW'(0) : AW'(HALF_DEPTH);
                wr_data   = SAMPLE_W'(85);
            end
            if (k == nsym * s) tx_en = 1'b0;
        end
        check_idle("R2", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1", 2);

        // R3: load both replicas of both branches while idle
        for (int br = 0; br < 2; br++) begin
            for (int a = 0; a < DEPTH; a++) begin
                host_write(br, a, br * DEPTH + a - 100);
                mem_m[br][a] = SAMPLE_W'(br * DEPTH + a - 100);
            end
        end
        check_idle("R2", 2);

        run(1'b0, 3, 6, 1'b1);
        // R3: accepted write while idle
        host_write(1, HALF_DEPTH, 99);
        mem_m[1][HALF_DEPTH] = SAMPLE_W'(99);
        run(1'b1, 3, 6, 1'b0);
        run(1'b0, MAX_LEN, 4, 1'b0);
        run(1'b1, 1, 8, 1'b1);
        run(1'b0, 1, 8, 1'b0);
        run(1'b1, MAX_LEN, 3, 1'b0);
        run(1'b0, 5, 5, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R4 watchdog expired: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule